// File: doc/BRIEF.md
# Low-Power Clock State Controller

This block sequences a processor through four power states: Run, Stop-Grant, Sleep and Deep Sleep. It follows three asynchronous, active-low request pins: stop-clock, sleep and deep-sleep. From its state it drives clock enables for the core, the bus interface and the interrupt controller, and an enable for the PLL. It also drives a flag that says whether snoops and interrupts may be serviced.

On the way from Run into Stop-Grant, the block raises a single-cycle request that tells the bus logic to issue a Stop-Grant acknowledge transaction. The sleep request is honoured only from Stop-Grant, and the deep-sleep request only from Sleep. Each request pin passes through a multi-flop synchroniser before the state machine sees it.

The asynchronous reset forces the Run state at once, from any state. Reset release is synchronised to the clock.

Top module: `lpcs_ctrl`

## Requirements
- R1: While reset is held, and after it is released with every request inactive, the block is in Run. Core, bus, interrupt-controller and PLL enables are 1, snoop_ok is 1 and ack_req is 0.
- R2: In Run, an asserted stop-clock request (stpclk_n=0) moves the block to Stop-Grant. ack_req is 1 for exactly one cycle, the cycle in which Stop-Grant is first visible. ack_req is never raised on any other transition.
- R3: In Stop-Grant, core_clk_en=0 while bus_clk_en, intc_clk_en and pll_en are 1, and snoop_ok=1.
- R4: In Stop-Grant, a released stop-clock request returns the block to Run. This takes priority over an asserted sleep request.
- R5: In Stop-Grant, with stop-clock still asserted, an asserted sleep request (slp_n=0) moves the block to Sleep. In Sleep, only pll_en is 1 and snoop_ok is 0.
- R6: The sleep and deep-sleep requests have no effect in Run. The deep-sleep request has no effect in Stop-Grant.
- R7: In Sleep, a released sleep request with deep-sleep inactive returns the block to Stop-Grant without an acknowledge pulse.
- R8: In Sleep, an asserted deep-sleep request (dpslp_n=0) moves the block to Deep Sleep, where every output enable and snoop_ok are 0. This takes priority over a released sleep request.
- R9: In Deep Sleep, a released deep-sleep request returns the block to Sleep. The stop-clock request has no effect in Sleep or Deep Sleep.
- R10: A change on a request pin, driven between clock edges, shows at the outputs after exactly the third following rising clock edge: two synchroniser stages plus the state register.
- R11: Driving rst_n low forces the Run outputs at once, without waiting for a clock edge, from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stpclk_n | input | 1 | Stop-clock request, active low, asynchronous |
| slp_n | input | 1 | Sleep request, active low, asynchronous |
| dpslp_n | input | 1 | Deep-sleep request, active low, asynchronous |
| core_clk_en | output | 1 | Core clock enable |
| bus_clk_en | output | 1 | Bus-interface clock enable |
| intc_clk_en | output | 1 | Interrupt-controller clock enable |
| pll_en | output | 1 | PLL enable |
| ack_req | output | 1 | One-cycle request to issue the Stop-Grant acknowledge |
| snoop_ok | output | 1 | Snoops and interrupts may be serviced |

## Verification
Two decisions can come due in the same cycle.

In Stop-Grant, a stop-clock release can coincide with a sleep assertion. The bench provokes this by driving both pins in the same half-cycle, and it expects Run (R4).

In Sleep, a deep-sleep assertion can coincide with a sleep release. Driven the same way, the bench expects Deep Sleep (R8).

The random phase draws all three pins freely, so further coincidences arise, including chains of transitions within one hold window. A bench model settles each chain and predicts the final enables and the number of acknowledge pulses.

// File: rtl/lpcs_pkg.sv
package lpcs_pkg;

  typedef enum logic [1:0] {
    LP_RUN     = 2'd0,
    LP_STOPGNT = 2'd1,
    LP_SLEEP   = 2'd2,
    LP_DEEP    = 2'd3
  } lp_state_e;

  typedef struct packed {
    logic core;
    logic bus;
    logic intc;
    logic pll;
    logic snoop;
  } lp_gate_s;

endpackage

// File: rtl/lpcs_rst_sync.sv
module lpcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] shift_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_ni) begin
        if (!arst_ni) shift_q <= '0;
        else          shift_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge arst_ni) begin
        if (!arst_ni) shift_q <= '0;
        else          shift_q <= {shift_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_no = shift_q[STAGES-1];
endmodule

// File: rtl/lpcs_sync.sv
module lpcs_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= din[g];
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= {chain_q[STAGES-2:0], din[g]};
      end
    end
    assign dout[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/lpcs_fsm.sv
module lpcs_fsm
  import lpcs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_ni,
  input  logic      stop_rq,
  input  logic      slp_rq,
  input  logic      dp_rq,
  output lp_state_e state_q,
  output logic      ack_q
);
  lp_state_e state_d;
  logic      ack_d;

  // Next-state decision; the order inside each arm sets priority.
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LP_RUN: begin
        if (stop_rq) state_d = LP_STOPGNT;
      end
      LP_STOPGNT: begin
        if (!stop_rq)    state_d = LP_RUN;
        else if (slp_rq) state_d = LP_SLEEP;
      end
      LP_SLEEP: begin
        if (dp_rq)        state_d = LP_DEEP;
        else if (!slp_rq) state_d = LP_STOPGNT;
      end
      LP_DEEP: begin
        if (!dp_rq) state_d = LP_SLEEP;
      end
      default: state_d = LP_RUN;
    endcase
  end

  // Acknowledge only on the Run to Stop-Grant edge.
  assign ack_d = (state_q == LP_RUN) && stop_rq;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LP_RUN;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
    end
  end
endmodule

// File: rtl/lpcs_gate_dec.sv
module lpcs_gate_dec
  import lpcs_pkg::*;
(
  input  lp_state_e state,
  output lp_gate_s  gates
);
  always_comb begin
    unique case (state)
      LP_RUN:     gates = '{core: 1'b1, bus: 1'b1, intc: 1'b1, pll: 1'b1, snoop: 1'b1};
      LP_STOPGNT: gates = '{core: 1'b0, bus: 1'b1, intc: 1'b1, pll: 1'b1, snoop: 1'b1};
      LP_SLEEP:   gates = '{core: 1'b0, bus: 1'b0, intc: 1'b0, pll: 1'b1, snoop: 1'b0};
      LP_DEEP:    gates = '{core: 1'b0, bus: 1'b0, intc: 1'b0, pll: 1'b0, snoop: 1'b0};
      default:    gates = '{core: 1'b1, bus: 1'b1, intc: 1'b1, pll: 1'b1, snoop: 1'b1};
    endcase
  end
endmodule

// File: rtl/lpcs_ctrl.sv
module lpcs_ctrl
  import lpcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stpclk_n,
  input  logic slp_n,
  input  logic dpslp_n,
  output logic core_clk_en,
  output logic bus_clk_en,
  output logic intc_clk_en,
  output logic pll_en,
  output logic ack_req,
  output logic snoop_ok
);
  localparam int NREQ = 3;

  logic            rst_int_n;
  logic [NREQ-1:0] req_pins_n;
  logic [NREQ-1:0] req_sync_n;
  logic            stop_rq, slp_rq, dp_rq;
  lp_state_e       state_q;
  lp_gate_s        gates;

  lpcs_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_ni(rst_n),
    .rst_no (rst_int_n)
  );

  assign req_pins_n = {dpslp_n, slp_n, stpclk_n};

  lpcs_sync #(.WIDTH(NREQ), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_ni(rst_int_n),
    .din   (req_pins_n),
    .dout  (req_sync_n)
  );

  assign stop_rq = ~req_sync_n[0];
  assign slp_rq  = ~req_sync_n[1];
  assign dp_rq   = ~req_sync_n[2];

  lpcs_fsm u_fsm (
    .clk    (clk),
    .rst_ni (rst_int_n),
    .stop_rq(stop_rq),
    .slp_rq (slp_rq),
    .dp_rq  (dp_rq),
    .state_q(state_q),
    .ack_q  (ack_req)
  );

  lpcs_gate_dec u_dec (
    .state(state_q),
    .gates(gates)
  );

  assign core_clk_en = gates.core;
  assign bus_clk_en  = gates.bus;
  assign intc_clk_en = gates.intc;
  assign pll_en      = gates.pll;
  assign snoop_ok    = gates.snoop;
endmodule

// File: rtl/lpcs_ctrl_chk.sv
module lpcs_ctrl_chk (
  input logic clk,
  input logic rst_int_n,
  input logic stop_rq,
  input logic slp_rq,
  input logic dp_rq,
  input logic core_en,
  input logic bus_en,
  input logic intc_en,
  input logic pll_en,
  input logic ack,
  input logic snoop
);
  a_r2_ack_single: assert property (@(posedge clk) disable iff (!rst_int_n)
    ack |=> !ack);

  a_r2_ack_from_run: assert property (@(posedge clk) disable iff (!rst_int_n)
    ack |-> ($past(core_en) && !core_en && bus_en));

  a_r3_sg_service: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!core_en && bus_en) |-> (intc_en && pll_en && snoop));

  a_r4_sg_exit: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!core_en && bus_en && !stop_rq) |=> core_en);

  a_r5_sleep_gates: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!bus_en) |-> (!core_en && !intc_en && !snoop));

  a_r6_run_holds: assert property (@(posedge clk) disable iff (!rst_int_n)
    (core_en && !stop_rq) |=> core_en);

  a_r8_deep_entry: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!bus_en && pll_en && dp_rq) |=> !pll_en);

  a_r9_deep_exit: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!pll_en && !dp_rq) |=> (pll_en && !bus_en));

  a_r8_pll_last: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!pll_en) |-> !bus_en);
endmodule

bind lpcs_ctrl lpcs_ctrl_chk u_chk (
  .clk      (clk),
  .rst_int_n(rst_int_n),
  .stop_rq  (stop_rq),
  .slp_rq   (slp_rq),
  .dp_rq    (dp_rq),
  .core_en  (core_clk_en),
  .bus_en   (bus_clk_en),
  .intc_en  (intc_clk_en),
  .pll_en   (pll_en),
  .ack      (ack_req),
  .snoop    (snoop_ok)
);

// File: tb/lpcs_ctrl_tb.sv
module lpcs_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int HOLD  = 6;

  logic clk, rst_n, stpclk_n, slp_n, dpslp_n;
  logic core_clk_en, bus_clk_en, intc_clk_en, pll_en, ack_req, snoop_ok;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  int mstate = 0; // 0 run, 1 stop-grant, 2 sleep, 3 deep

  lpcs_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .stpclk_n(stpclk_n), .slp_n(slp_n), .dpslp_n(dpslp_n),
    .core_clk_en(core_clk_en), .bus_clk_en(bus_clk_en), .intc_clk_en(intc_clk_en),
    .pll_en(pll_en), .ack_req(ack_req), .snoop_ok(snoop_ok)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic int next_st(int s, bit stop, bit slp, bit dp);
    case (s)
      0: return stop ? 1 : 0;
      1: return !stop ? 0 : (slp ? 2 : 1);
      2: return dp ? 3 : (!slp ? 1 : 2);
      default: return !dp ? 2 : 3;
    endcase
  endfunction

  function automatic logic [4:0] gates_of(int s);
    case (s)
      0: return 5'b11111;
      1: return 5'b01111;
      2: return 5'b00010;
      default: return 5'b00000;
    endcase
  endfunction

  function automatic logic [4:0] outs();
    return {core_clk_en, bus_clk_en, intc_clk_en, pll_en, snoop_ok};
  endfunction

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Drive pins, hold, and compare against the settled model.
  task automatic step(input logic s, input logic l, input logic d, input string req);
    int s_now = mstate;
    int exp_ack = 0;
    int acks = 0;
    @(negedge clk);
    stpclk_n = s; slp_n = l; dpslp_n = d;
    for (int k = 0; k < 4; k++) begin
      int n = next_st(s_now, !s, !l, !d);
      if (s_now == 0 && n == 1) exp_ack++;
      s_now = n;
    end
    for (int k = 0; k < HOLD; k++) begin
      @(negedge clk);
      if (ack_req === 1'b1) acks++;
    end
    mstate = s_now;
    check(req, outs(), gates_of(mstate));
    check({req, " ack count"}, 5'(acks), 5'(exp_ack));
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'h5A17));
    rst_n = 1'b0; stpclk_n = 1'b1; slp_n = 1'b1; dpslp_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 in reset", outs(), 5'b11111);
    check("R1 ack in reset", {4'b0, ack_req}, 5'b0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 after release", outs(), 5'b11111);

    // R6: sleep and deep-sleep ignored in Run
    step(1, 0, 0, "R6 run ignores sleep/deep");
    step(1, 1, 1, "R6 release");
    // R10: exact latency and R2 pulse
    @(negedge clk);
    stpclk_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 before third edge", outs(), 5'b11111);
    @(negedge clk);
    check("R10 at third edge", outs(), 5'b01111);
    check("R2 ack pulse", {4'b0, ack_req}, 5'b00001);
    @(negedge clk);
    check("R2 ack drops", {4'b0, ack_req}, 5'b0);
    mstate = 1;
    step(0, 1, 0, "R3 stop-grant ignores deep");
    step(0, 0, 1, "R5 enter sleep");
    step(0, 1, 1, "R7 back to stop-grant");
    step(0, 0, 1, "R5 sleep again");
    step(1, 0, 1, "R9 stop-clock ignored in sleep");
    step(1, 1, 0, "R8 deep wins over sleep release");
    step(0, 1, 0, "R9 stop-clock ignored in deep");
    step(0, 0, 1, "R9 deep exit to sleep");
    step(0, 1, 1, "R7 sleep exit");
    step(1, 0, 1, "R4 run wins over sleep");

    // R11: asynchronous reset from Deep Sleep
    step(0, 0, 0, "R8 chain to deep");
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1 check("R11 immediate reset", outs(), 5'b11111);
    stpclk_n = 1'b1; slp_n = 1'b1; dpslp_n = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
    mstate = 0;
    check("R11 after release", outs(), 5'b11111);

    for (int i = 0; i < 80; i++) begin
      logic s, l, d;
      s = ($urandom % 4) != 0;
      l = ($urandom % 3) != 0;
      d = ($urandom % 3) != 0;
      if (($urandom % 2) == 0) s = 1'b0;
      step(s, l, d, "R3/R5/R9 random");
    end
    summary();
  end
endmodule